// File: doc/BRIEF.md
# Debug-Port Flash Mass-Erase Sequencer

This block is a small bus master that drives the whole-device flash erase handshake through the debug access-port register file of a target microcontroller. A single start pulse launches a fixed series of single-word register accesses on a request/acknowledge bus with an 8-bit register offset and 32-bit data. The series runs as follows. The master asks for a system reset and waits for the flash to report ready while the reset indication is clear. It then sets the erase-in-progress flag and waits for the erase acknowledge. Next it waits for the erase-in-progress flag to clear, and finally it writes the control register back to zero.

Each waiting step reads a register repeatedly and compares it against a mask and a wanted value. A fixed number of idle cycles separates consecutive reads, and a parameter caps the number of attempts. An optional hardware reset output is held asserted for the whole run when the caller enables it. The run ends in one of three outcomes, each with its own sticky flag: completion, poll timeout or bus error. Any bus error stops the run at once. Any early stop also releases the reset output.

Top module: `mers_top`

## Requirements
- R1: After reset, busReq, busy, done, timedOut, errFlag and tgtResetOut are all 0.
- R2: A run issues, in this order: a write of 0x08 to offset 0x04, status reads at offset 0x00, a write of 0x09 to offset 0x04, status reads at offset 0x00, control reads at offset 0x04, and a write of 0x00 to offset 0x04.
- R3: The readiness poll advances only when status bit 1 reads 1 and status bit 3 reads 0. Other status bits are ignored, and a read with both bit 1 and bit 3 set does not advance.
- R4: The acknowledge poll advances when status bit 0 reads 1. The completion poll advances when control bit 0 reads 0.
- R5: A poll that sees POLL_LIMIT non-matching reads stops the run with timedOut set. A match on read number POLL_LIMIT still advances.
- R6: Between two consecutive reads of the same poll, busReq is low for exactly POLL_GAP cycles.
- R7: An acknowledge that carries busErr ends the run after that access. errFlag is set and no further access is issued.
- R8: When useHwReset is 1 at start, tgtResetOut is 1 during every access of the run. It is 0 whenever the block is idle, and it is never asserted when useHwReset is 0.
- R9: A start pulse while busy is ignored, and the access sequence is unchanged.
- R10: Exactly one of done, timedOut and errFlag is set at the end of a run. That flag holds until the next accepted start, which clears all three.
- R11: While busReq is high and not yet acknowledged, busAddr, busWrite and busWdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| useHwReset | input | 1 | Drive tgtResetOut during the run |
| busReq | output | 1 | Access request, held until acknowledged |
| busWrite | output | 1 | 1 for write, 0 for read |
| busAddr | output | ADDR_W | Register offset |
| busWdata | output | DATA_W | Write data |
| busAck | input | 1 | Access complete (one cycle) |
| busErr | input | 1 | Error response, valid with busAck |
| busRdata | input | DATA_W | Read data, valid with busAck |
| tgtResetOut | output | 1 | Hardware reset to the target, active high |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky: run completed |
| timedOut | output | 1 | Sticky: a poll ran out of attempts |
| errFlag | output | 1 | Sticky: a bus error aborted the run |

## Verification
A start pulse sampled at a rising edge shows up one cycle later. By the next falling edge busy and busReq are already high and all three flags are clear. The bench checks this at that falling edge. An acknowledge driven before a rising edge takes effect at that edge: the next access request, the gap, or the outcome flag appears within the same cycle. The bench's target model and monitor therefore work on falling edges. It measures gaps by counting low falling-edge samples of busReq between a non-matching read and the next request, and it reads the flags at the first falling edge where busy is low.

// File: rtl/mers_pkg.sv
package mers_pkg;
  localparam logic [7:0] OFS_STATUS  = 8'h00;
  localparam logic [7:0] OFS_CONTROL = 8'h04;
  localparam int CTL_ERASE_BIT  = 0;
  localparam int CTL_SYSRST_BIT = 3;
  localparam int STS_ACK_BIT    = 0;
  localparam int STS_READY_BIT  = 1;
  localparam int STS_SYSRST_BIT = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSTREQ, ST_RDYPOLL, ST_ERASE, ST_ACKPOLL, ST_FINPOLL, ST_RELEASE
  } stepT;

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_GAP} phaseT;

  typedef struct packed {
    logic clrPoll;
    logic bumpPoll;
    logic loadGap;
    logic tickGap;
  } strobeT;
endpackage

// File: rtl/mers_dpath.sv
module mers_dpath
  import mers_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int POLL_LIMIT = 3000,
  parameter int POLL_GAP   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepT              step,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqWrite,
  output logic [DATA_W-1:0] reqWdata,
  output logic              pollMatch,
  output logic              pollSpent,
  output logic              gapDone
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cmpMask, cmpWant;
  logic [CNT_W-1:0]  pollCnt;
  logic [GAP_W-1:0]  gapCnt;

  // Access decode per step
  always_comb begin
    reqAddr  = ADDR_W'(OFS_STATUS);
    reqWrite = 1'b0;
    reqWdata = '0;
    cmpMask  = '0;
    cmpWant  = '0;
    case (step)
      ST_RSTREQ: begin
        reqAddr  = ADDR_W'(OFS_CONTROL);
        reqWrite = 1'b1;
        reqWdata = ONE << CTL_SYSRST_BIT;
      end
      ST_RDYPOLL: begin
        cmpMask = (ONE << STS_READY_BIT) | (ONE << STS_SYSRST_BIT);
        cmpWant = ONE << STS_READY_BIT;
      end
      ST_ERASE: begin
        reqAddr  = ADDR_W'(OFS_CONTROL);
        reqWrite = 1'b1;
        reqWdata = (ONE << CTL_SYSRST_BIT) | (ONE << CTL_ERASE_BIT);
      end
      ST_ACKPOLL: begin
        cmpMask = ONE << STS_ACK_BIT;
        cmpWant = ONE << STS_ACK_BIT;
      end
      ST_FINPOLL: begin
        reqAddr = ADDR_W'(OFS_CONTROL);
        cmpMask = ONE << CTL_ERASE_BIT;
      end
      ST_RELEASE: begin
        reqAddr  = ADDR_W'(OFS_CONTROL);
        reqWrite = 1'b1;
      end
      default: ;
    endcase
  end

  assign pollMatch = ((rdData & cmpMask) == cmpWant);
  assign pollSpent = (pollCnt == CNT_W'(POLL_LIMIT - 1));
  assign gapDone   = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (stb.clrPoll) begin
      pollCnt <= '0;
    end else if (stb.bumpPoll) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (stb.loadGap) begin
      gapCnt <= GAP_W'(POLL_GAP - 1);
    end else if (stb.tickGap) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CNT_W'(POLL_LIMIT));

  a_r6_gap_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadGap |=> gapCnt == GAP_W'(POLL_GAP - 1));
endmodule

// File: rtl/mers_ctrl.sv
module mers_ctrl
  import mers_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   useHwReset,
  input  logic   busAck,
  input  logic   busErr,
  input  logic   pollMatch,
  input  logic   pollSpent,
  input  logic   gapDone,
  output stepT   step,
  output strobeT stb,
  output logic   busReq,
  output logic   busy,
  output logic   done,
  output logic   timedOut,
  output logic   errFlag,
  output logic   tgtResetOut
);
  phaseT phase;
  logic  ackNow, isPoll, stepOk, missNow;

  function automatic stepT nextStep(input stepT s);
    case (s)
      ST_RSTREQ:  return ST_RDYPOLL;
      ST_RDYPOLL: return ST_ERASE;
      ST_ERASE:   return ST_ACKPOLL;
      ST_ACKPOLL: return ST_FINPOLL;
      ST_FINPOLL: return ST_RELEASE;
      default:    return ST_IDLE;
    endcase
  endfunction

  assign ackNow  = (phase == PH_REQ) && busAck;
  assign isPoll  = (step == ST_RDYPOLL) || (step == ST_ACKPOLL) || (step == ST_FINPOLL);
  assign stepOk  = ackNow && !busErr && (!isPoll || pollMatch);
  assign missNow = ackNow && !busErr && isPoll && !pollMatch;
  assign busReq  = (phase == PH_REQ);
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    stb          = '0;
    stb.clrPoll  = stepOk || ((phase == PH_IDLE) && start);
    stb.bumpPoll = missNow && !pollSpent;
    stb.loadGap  = missNow && !pollSpent;
    stb.tickGap  = (phase == PH_GAP) && !gapDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      step        <= ST_IDLE;
      done        <= 1'b0;
      timedOut    <= 1'b0;
      errFlag     <= 1'b0;
      tgtResetOut <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase       <= PH_REQ;
          step        <= ST_RSTREQ;
          done        <= 1'b0;
          timedOut    <= 1'b0;
          errFlag     <= 1'b0;
          tgtResetOut <= useHwReset;
        end
        PH_REQ: if (ackNow) begin
          if (busErr) begin
            errFlag     <= 1'b1;
            phase       <= PH_IDLE;
            step        <= ST_IDLE;
            tgtResetOut <= 1'b0;
          end else if (stepOk) begin
            if (step == ST_RELEASE) begin
              done        <= 1'b1;
              phase       <= PH_IDLE;
              step        <= ST_IDLE;
              tgtResetOut <= 1'b0;
            end else begin
              step <= nextStep(step);
            end
          end else if (pollSpent) begin
            timedOut    <= 1'b1;
            phase       <= PH_IDLE;
            step        <= ST_IDLE;
            tgtResetOut <= 1'b0;
          end else begin
            phase <= PH_GAP;
          end
        end
        PH_GAP: if (gapDone) phase <= PH_REQ;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, timedOut, errFlag}));

  a_r7_err_abort: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && busErr |=> !busy && errFlag && !tgtResetOut);

  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tgtResetOut);

  a_r9_busy_keep: assert property (@(posedge clk) disable iff (!rstN)
    busy && start && !busAck |=> busy);
endmodule

// File: rtl/mers_top.sv
module mers_top
  import mers_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int POLL_LIMIT = 3000,
  parameter int POLL_GAP   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              useHwReset,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              tgtResetOut,
  output logic              busy,
  output logic              done,
  output logic              timedOut,
  output logic              errFlag
);
  stepT   step;
  strobeT stb;
  logic   pollMatch, pollSpent, gapDone;

  mers_ctrl i_ctrl (
    .clk, .rstN, .start, .useHwReset, .busAck, .busErr,
    .pollMatch, .pollSpent, .gapDone,
    .step, .stb, .busReq, .busy, .done, .timedOut, .errFlag, .tgtResetOut
  );

  mers_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)
  ) i_dpath (
    .clk, .rstN, .step, .stb, .rdData(busRdata),
    .reqAddr(busAddr), .reqWrite(busWrite), .reqWdata(busWdata),
    .pollMatch, .pollSpent, .gapDone
  );

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite) && $stable(busWdata));
endmodule

// File: tb/test_mers_top.sv
module test_mers_top;
  localparam int LIM = 12;
  localparam int GAP = 5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, useHwReset = 1'b0;
  logic busReq, busWrite, busAck = 1'b0, busErr = 1'b0;
  logic [7:0]  busAddr;
  logic [31:0] busWdata, busRdata = '0;
  logic tgtResetOut, busy, done, timedOut, errFlag;

  always #10 clk = ~clk;

  mers_top #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) i_mers_top (
    .clk, .rstN, .start, .useHwReset, .busReq, .busWrite, .busAddr, .busWdata,
    .busAck, .busErr, .busRdata, .tgtResetOut, .busy, .done, .timedOut, .errFlag
  );

  int checks = 0, errors = 0;

  // target model configuration
  int rdyN, ackN, finN, errIdx, lat, waitCnt, tgtWait;
  bit forceBoth, curHw;
  int nTr, statRd, ctrlRd, hwBad, lowCnt;
  logic [31:0] lastWr;
  bit lastMiss, prevReq;
  bit          logWr[64];
  logic [7:0]  logAddr[64];
  logic [31:0] logData[64];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    // gap monitor first (R6) and reset-line monitor (R8)
    if (busReq && !prevReq && lastMiss)
      chk(lowCnt == GAP, "R6", "idle cycles between poll reads", lowCnt, GAP);
    if (busReq) lowCnt = 0; else lowCnt++;
    prevReq = busReq;
    if (busReq && (tgtResetOut !== curHw)) hwBad++;
    // target model
    if (busAck) begin
      busAck = 1'b0; busErr = 1'b0; waitCnt = 0;
    end else if (busReq) begin
      if (waitCnt >= tgtWait) begin
        bit hit;
        int n;
        hit = 1'b1;
        if (busWrite) begin
          lastWr = busWdata; statRd = 0; ctrlRd = 0; busRdata = $urandom;
        end else if (busAddr == 8'h00) begin
          statRd++; n = statRd;
          if (lastWr == 32'h8) begin
            hit = (n >= rdyN);
            if (hit) busRdata = 32'h2 | ($urandom << 4);
            else if (forceBoth) busRdata = 32'hA | ($urandom << 4);
            else begin
              case ($urandom_range(0, 2))
                0: busRdata = 32'h0;
                1: busRdata = 32'h8;
                default: busRdata = 32'hA;
              endcase
              busRdata = busRdata | ($urandom << 4) | {31'd0, $urandom_range(0, 1) == 1};
            end
          end else begin
            hit = (n >= ackN);
            busRdata = ($urandom & 32'hFFFF_FFFE) | {31'd0, hit};
          end
        end else begin
          ctrlRd++; n = ctrlRd;
          hit = (n >= finN);
          busRdata = ($urandom & 32'hFFFF_FFFE) | {31'd0, !hit};
        end
        lastMiss = !busWrite && !hit;
        if (nTr < 64) begin
          logWr[nTr] = busWrite; logAddr[nTr] = busAddr; logData[nTr] = busWdata;
        end
        busAck = 1'b1;
        busErr = (nTr == errIdx);
        nTr++;
        tgtWait = $urandom_range(0, lat);
      end else waitCnt++;
    end
  end

  function automatic int expCount();
    int c;
    if (rdyN > LIM) c = 1 + LIM;
    else if (ackN > LIM) c = 2 + rdyN + LIM;
    else if (finN > LIM) c = 2 + rdyN + ackN + LIM;
    else c = rdyN + ackN + finN + 3;
    if (errIdx >= 0 && errIdx < c) c = errIdx + 1;
    return c;
  endfunction

  function automatic int expOutcome(); // 0 done, 1 timeout, 2 error
    int c;
    c = expCount();
    if (errIdx >= 0 && errIdx == c - 1) return 2;
    if (rdyN > LIM || ackN > LIM || finN > LIM) return 1;
    return 0;
  endfunction

  function automatic logic [40:0] expTr(input int k); // {wr, addr, data}
    if (k == 0) return {1'b1, 8'h04, 32'h8};
    if (k <= rdyN) return {1'b0, 8'h00, 32'h0};
    if (k == rdyN + 1) return {1'b1, 8'h04, 32'h9};
    if (k <= rdyN + 1 + ackN) return {1'b0, 8'h00, 32'h0};
    if (k <= rdyN + 1 + ackN + finN) return {1'b0, 8'h04, 32'h0};
    return {1'b1, 8'h04, 32'h0};
  endfunction

  task automatic runSeq(input int r, input int a, input int f, input bit hw, input int e,
                        input int l, input bit both, input bit midStart, input string tag);
    int c, o, guard;
    rdyN = r; ackN = a; finN = f; errIdx = e; lat = l; forceBoth = both;
    nTr = 0; statRd = 0; ctrlRd = 0; lastWr = 0; lastMiss = 0; hwBad = 0;
    tgtWait = 0; waitCnt = 0;
    @(negedge clk); useHwReset = hw; curHw = hw; start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10: accepted start clears flags, run visible one cycle after the sampling edge
    chk(busy && !done && !timedOut && !errFlag, "R10", {tag, " flags cleared on start"},
        {busy, done, timedOut, errFlag}, 4'b1000);
    if (midStart) begin
      repeat (6) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    c = expCount(); o = expOutcome();
    chk(nTr == c, midStart ? "R9" : "R2", {tag, " access count"}, nTr, c);
    for (int k = 0; k < c && k < nTr && k < 64; k++) begin
      logic [40:0] x;
      x = expTr(k);
      if (x[40])
        chk(logWr[k] && logAddr[k] == x[39:32] && logData[k] == x[31:0], "R2",
            {tag, " write access"}, {logWr[k], logAddr[k], logData[k]}, x);
      else
        chk(!logWr[k] && logAddr[k] == x[39:32], "R2", {tag, " read access"},
            {logWr[k], logAddr[k]}, x[40:32]);
    end
    case (o)
      0: chk(done && !timedOut && !errFlag, "R4", {tag, " completion flag"}, {done, timedOut, errFlag}, 3'b100);
      1: chk(!done && timedOut && !errFlag, "R5", {tag, " timeout flag"}, {done, timedOut, errFlag}, 3'b010);
      default: chk(!done && !timedOut && errFlag, "R7", {tag, " error flag"}, {done, timedOut, errFlag}, 3'b001);
    endcase
    chk(hwBad == 0, "R8", {tag, " reset line during accesses"}, hwBad, 0);
    chk(tgtResetOut == 1'b0, "R8", {tag, " reset line released"}, tgtResetOut, 0);
    repeat (10) @(negedge clk);
    chk(nTr == c, "R7", {tag, " no access after end"}, nTr, c);
    chk({done, timedOut, errFlag} == (3'b100 >> o), "R10", {tag, " flag holds"},
        {done, timedOut, errFlag}, 3'b100 >> o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(!busReq && !busy && !done && !timedOut && !errFlag && !tgtResetOut, "R1",
        "outputs in reset", {busReq, busy, done, timedOut, errFlag, tgtResetOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busReq && !busy && !tgtResetOut, "R1", "idle after reset", {busReq, busy, tgtResetOut}, 0);

    runSeq(3, 2, 2, 1, -1, 0, 0, 0, "R2 basic hw");
    runSeq(4, 1, 1, 0, -1, 2, 1, 0, "R3 ready+sysres rejected");
    runSeq(1, 3, 4, 1, -1, 1, 0, 0, "R4 ack/complete polls");
    runSeq(LIM, 1, LIM, 1, -1, 0, 0, 0, "R5 last attempt matches");
    runSeq(LIM + 3, 1, 1, 1, -1, 1, 0, 0, "R5 ready timeout");
    runSeq(2, 2, LIM + 4, 0, -1, 0, 0, 0, "R5 completion timeout");
    runSeq(2, 1, 1, 1, 0, 0, 0, 0, "R7 error on first write");
    runSeq(4, 2, 2, 1, 3, 1, 0, 0, "R7 error inside poll");
    runSeq(4, 2, 2, 1, -1, 0, 0, 1, "R9 start while busy");
    for (int i = 0; i < 10; i++)
      runSeq($urandom_range(1, 6), $urandom_range(1, 4), $urandom_range(1, 5),
             1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0) ? $urandom_range(0, 10) : -1,
             $urandom_range(0, 3), 0, 0, "random");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule